// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches for a small in-order core. Two component predictors run side by side. The first is a fixed rule: a branch whose offset is negative, so it jumps backward, is guessed taken, and a branch that jumps forward is guessed not-taken. The second is a small table of one-bit direction entries, indexed by joining recent global branch outcomes with a few low PC bits. A table of saturating selector counters, indexed by the branch PC, decides which of the two components supplies the final guess.

The lookup port takes the branch PC and the offset sign and gives its guess in the same cycle. It also gives the current global history, which the pipeline carries with the branch. When the branch resolves, the update port receives the same PC, the offset sign, the carried history and the real outcome. The update trains the selector and the direction table, shifts the outcome into the history, and adds one to a correct or a wrong counter for that branch's direction. At reset every selector sits at the weakest value that still favours the fixed rule, so a new core starts out with plain backward-taken behaviour.

Top module: `tourney_bpred`

## Requirements
- R1: After reset the history is 0, all four statistics counters are 0, every direction entry holds 0 (not-taken), and every selector holds the weak value 3 (binary 011). So every lookup gives taken for a backward branch and not-taken for a forward one.
- R2: When the selector entry's top bit is 0, the guess equals the fixed rule: taken when `predBackward` is 1, not-taken when it is 0.
- R3: The direction table index is {history[5:0], PC[2:1]}, with the history in the upper 6 bits. On each accepted update the entry at that index is overwritten with the resolved outcome.
- R4: The selector index is PC[6:1]. A selector changes only when the fixed rule and the direction entry disagree. It then steps by one toward the component that matched the outcome, saturating at 0 and at 7.
- R5: When the selector entry's top bit is 1, the guess is the direction table entry at the lookup index.
- R6: Each accepted update shifts the history left by one place and puts the outcome (1 = taken) in bit 0. `predHist` always shows the current history.
- R7: The update indexes the direction table with the history supplied on `updHist`, not with the current history register.
- R8: Each accepted update adds one to exactly one counter. The guess that the tables give at the update index decides whether the branch was correct or wrong, and `updBackward` picks the backward or the forward counter.
- R9: When a lookup and an update fall in the same cycle, the lookup sees the table, selector and history values from before that update.
- R10: While `updValid` is 0, the history, the tables and the counters keep their values, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | 32 | PC of the branch being looked up |
| predBackward | input | 1 | 1 when the looked-up branch offset is negative |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| predHist | output | 6 | Current global history, carried with the branch |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | 32 | PC of the resolved branch |
| updBackward | input | 1 | 1 when the resolved branch offset is negative |
| updHist | input | 6 | History captured at lookup time |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| cntHitFwd | output | 32 | Correctly guessed forward branches |
| cntHitBwd | output | 32 | Correctly guessed backward branches |
| cntMissFwd | output | 32 | Wrongly guessed forward branches |
| cntMissBwd | output | 32 | Wrongly guessed backward branches |

## Verification
A lookup and an update can fall in the same cycle, and both may hit the same selector and direction entry. The bench drives both ports at once on a PC that the update is about to retrain. It expects the guess worked out from the model state before that update, and after the clock edge it looks up the same entry again and expects the retrained state. A separate case sends an update whose carried history is older than the current register. Later lookups then show whether the write went to the entry named by the carried history.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // strobes issued by control toward the datapath for one update
  typedef struct packed {
    logic gsWrite;
    logic histShift;
    logic chInc;
    logic chDec;
    logic hitFwd;
    logic hitBwd;
    logic missFwd;
    logic missBwd;
  } tbp_strobe_t;
endpackage

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            updValid,
  input  logic            updBackward,
  input  logic            updTaken,
  input  logic            updGsBit,
  input  logic [CH_W-1:0] updChVal,
  output tbp_strobe_t     strb
);
  logic staticGuess;
  logic finalGuess;
  logic correct;
  logic disagree;

  always_comb begin
    staticGuess = updBackward;
    finalGuess  = updChVal[CH_W-1] ? updGsBit : staticGuess;
    correct     = (finalGuess == updTaken);
    disagree    = (staticGuess != updGsBit);

    strb.gsWrite   = updValid;
    strb.histShift = updValid;
    strb.chInc     = updValid && disagree && (updGsBit == updTaken)
                     && (updChVal != {CH_W{1'b1}});
    strb.chDec     = updValid && disagree && (staticGuess == updTaken)
                     && (updChVal != {CH_W{1'b0}});
    strb.hitFwd    = updValid && correct  && !updBackward;
    strb.hitBwd    = updValid && correct  &&  updBackward;
    strb.missFwd   = updValid && !correct && !updBackward;
    strb.missBwd   = updValid && !correct &&  updBackward;
  end
endmodule

// File: rtl/tbp_dpath.sv
module tbp_dpath
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 6,
  parameter int GS_PC_W = 2,
  parameter int CH_PC_W = 6,
  parameter int CH_W    = 3,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predBackward,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic [PC_W-1:0]   updPc,
  input  logic [HIST_W-1:0] updHist,
  input  logic              updTaken,
  output logic              updGsBit,
  output logic [CH_W-1:0]   updChVal,
  input  tbp_strobe_t       strb,
  output logic [CNT_W-1:0]  cntHitFwd,
  output logic [CNT_W-1:0]  cntHitBwd,
  output logic [CNT_W-1:0]  cntMissFwd,
  output logic [CNT_W-1:0]  cntMissBwd
);
  localparam int GS_IDX_W = HIST_W + GS_PC_W;
  localparam int GS_DEPTH = 1 << GS_IDX_W;
  localparam int CH_DEPTH = 1 << CH_PC_W;
  localparam logic [CH_W-1:0] CH_WEAK = CH_W'((1 << (CH_W - 1)) - 1);

  logic [GS_DEPTH-1:0] gsTab;
  logic [CH_W-1:0]     chTab [CH_DEPTH];
  logic [HIST_W-1:0]   histReg;

  logic [GS_IDX_W-1:0] predGsIdx, updGsIdx;
  logic [CH_PC_W-1:0]  predChIdx, updChIdx;
  logic [CH_W-1:0]     predChVal;

  // index bits start at PC bit 1 so halfword branches get distinct entries
  assign predGsIdx = {histReg, predPc[GS_PC_W:1]};
  assign updGsIdx  = {updHist, updPc[GS_PC_W:1]};
  assign predChIdx = predPc[CH_PC_W:1];
  assign updChIdx  = updPc[CH_PC_W:1];

  assign predChVal = chTab[predChIdx];
  assign predTaken = predChVal[CH_W-1] ? gsTab[predGsIdx] : predBackward;
  assign predHist  = histReg;
  assign updGsBit  = gsTab[updGsIdx];
  assign updChVal  = chTab[updChIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gsTab   <= '0;
      histReg <= '0;
    end else begin
      if (strb.gsWrite)   gsTab[updGsIdx] <= updTaken;
      if (strb.histShift) histReg <= {histReg[HIST_W-2:0], updTaken};
    end
  end

  for (genvar g = 0; g < CH_DEPTH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chTab[g] <= CH_WEAK;
      end else if (updChIdx == CH_PC_W'(g)) begin
        if (strb.chInc)      chTab[g] <= chTab[g] + 1'b1;
        else if (strb.chDec) chTab[g] <= chTab[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntHitFwd  <= '0;
      cntHitBwd  <= '0;
      cntMissFwd <= '0;
      cntMissBwd <= '0;
    end else begin
      if (strb.hitFwd)  cntHitFwd  <= cntHitFwd  + 1'b1;
      if (strb.hitBwd)  cntHitBwd  <= cntHitBwd  + 1'b1;
      if (strb.missFwd) cntMissFwd <= cntMissFwd + 1'b1;
      if (strb.missBwd) cntMissBwd <= cntMissBwd + 1'b1;
    end
  end
endmodule

// File: rtl/tourney_bpred.sv
module tourney_bpred
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 6,
  parameter int GS_PC_W = 2,
  parameter int CH_PC_W = 6,
  parameter int CH_W    = 3,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predBackward,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updBackward,
  input  logic [HIST_W-1:0] updHist,
  input  logic              updTaken,
  output logic [CNT_W-1:0]  cntHitFwd,
  output logic [CNT_W-1:0]  cntHitBwd,
  output logic [CNT_W-1:0]  cntMissFwd,
  output logic [CNT_W-1:0]  cntMissBwd
);
  tbp_strobe_t     strb;
  logic            updGsBit;
  logic [CH_W-1:0] updChVal;

  tbp_ctrl #(.CH_W(CH_W)) u_ctrl (
    .updValid    (updValid),
    .updBackward (updBackward),
    .updTaken    (updTaken),
    .updGsBit    (updGsBit),
    .updChVal    (updChVal),
    .strb        (strb)
  );

  tbp_dpath #(
    .PC_W(PC_W), .HIST_W(HIST_W), .GS_PC_W(GS_PC_W),
    .CH_PC_W(CH_PC_W), .CH_W(CH_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .predPc       (predPc),
    .predBackward (predBackward),
    .predTaken    (predTaken),
    .predHist     (predHist),
    .updPc        (updPc),
    .updHist      (updHist),
    .updTaken     (updTaken),
    .updGsBit     (updGsBit),
    .updChVal     (updChVal),
    .strb         (strb),
    .cntHitFwd    (cntHitFwd),
    .cntHitBwd    (cntHitBwd),
    .cntMissFwd   (cntMissFwd),
    .cntMissBwd   (cntMissBwd)
  );
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int HIST_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [HIST_W-1:0] predHist,
  input logic              updValid,
  input logic              updBackward,
  input logic              updTaken,
  input logic [CNT_W-1:0]  cntHitFwd,
  input logic [CNT_W-1:0]  cntHitBwd,
  input logic [CNT_W-1:0]  cntMissFwd,
  input logic [CNT_W-1:0]  cntMissBwd
);
  logic [CNT_W+1:0] cntSum;
  assign cntSum = (CNT_W+2)'(cntHitFwd) + (CNT_W+2)'(cntHitBwd)
                + (CNT_W+2)'(cntMissFwd) + (CNT_W+2)'(cntMissBwd);

  // R6: history takes the outcome in bit 0 after an update
  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> predHist == {$past(predHist[HIST_W-2:0]), $past(updTaken)});

  // R10: idle cycles leave history and counters alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(predHist) && $stable(cntSum));

  // R8: exactly one counter advances per update
  p_one_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> cntSum == $past(cntSum) + 1'b1);

  // R8: a backward update leaves the forward counters untouched
  p_dir_split_r8: assert property (@(posedge clk) disable iff (!rstN)
    updValid && updBackward |=> $stable(cntHitFwd) && $stable(cntMissFwd));

  // R8: a forward update leaves the backward counters untouched
  p_dir_split_fwd_r8: assert property (@(posedge clk) disable iff (!rstN)
    updValid && !updBackward |=> $stable(cntHitBwd) && $stable(cntMissBwd));
endmodule

bind tourney_bpred tbp_checker #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .predHist(predHist), .updValid(updValid),
  .updBackward(updBackward), .updTaken(updTaken),
  .cntHitFwd(cntHitFwd), .cntHitBwd(cntHitBwd),
  .cntMissFwd(cntMissFwd), .cntMissBwd(cntMissBwd)
);

// File: tb/sim_tourney_bpred.sv
module sim_tourney_bpred;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] predPc = '0;
  logic        predBackward = 1'b0;
  logic        predTaken;
  logic [5:0]  predHist;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updBackward = 1'b0;
  logic [5:0]  updHist = '0;
  logic        updTaken = 1'b0;
  logic [31:0] cntHitFwd, cntHitBwd, cntMissFwd, cntMissBwd;

  always #4 clk = ~clk;

  tourney_bpred u0 (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predBackward(predBackward),
    .predTaken(predTaken), .predHist(predHist), .updValid(updValid),
    .updPc(updPc), .updBackward(updBackward), .updHist(updHist),
    .updTaken(updTaken), .cntHitFwd(cntHitFwd), .cntHitBwd(cntHitBwd),
    .cntMissFwd(cntMissFwd), .cntMissBwd(cntMissBwd)
  );

  // reference model built from the requirements
  bit [255:0] refGs;
  bit [2:0]   refCh [64];
  bit [5:0]   refHist;
  int refHitF, refHitB, refMissF, refMissB;
  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit refGuess(input bit [31:0] pc, input bit bwd, input bit [5:0] h);
    bit [2:0] c;
    c = refCh[pc[6:1]];
    return c[2] ? refGs[{h, pc[2:1]}] : bwd;
  endfunction

  task automatic refReset();
    refGs = '0;
    refHist = '0;
    for (int i = 0; i < 64; i++) refCh[i] = 3'd3;
    refHitF = 0; refHitB = 0; refMissF = 0; refMissB = 0;
  endtask

  task automatic refUpdate(input bit [31:0] pc, input bit bwd, input bit [5:0] h, input bit tk);
    bit g, s, f;
    g = refGs[{h, pc[2:1]}];
    s = bwd;
    f = refGuess(pc, bwd, h);
    if (g != s) begin
      if (g == tk && refCh[pc[6:1]] != 3'd7) refCh[pc[6:1]]++;
      if (s == tk && refCh[pc[6:1]] != 3'd0) refCh[pc[6:1]]--;
    end
    if (f == tk) begin if (bwd) refHitB++; else refHitF++; end
    else begin if (bwd) refMissB++; else refMissF++; end
    refGs[{h, pc[2:1]}] = tk;
    refHist = {refHist[4:0], tk};
  endtask

  // lookup and compare against the model, at mid-cycle
  task automatic look(input string req, input bit [31:0] pc, input bit bwd);
    @(negedge clk);
    predPc = pc; predBackward = bwd;
    #1;
    chk(req, predTaken, refGuess(pc, bwd, refHist));
  endtask

  task automatic update(input bit [31:0] pc, input bit bwd, input bit [5:0] h, input bit tk);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updBackward = bwd; updHist = h; updTaken = tk;
    refUpdate(pc, bwd, h, tk);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic lookAndUpdate(input string req, input bit [31:0] pc, input bit bwd, input bit tk);
    bit [5:0] h;
    look(req, pc, bwd);
    h = predHist;
    chk("R6 hist out", predHist, refHist);
    update(pc, bwd, h, tk);
  endtask

  task automatic chkCounters(input string req);
    chk({req, " hitF"},  cntHitFwd,  refHitF);
    chk({req, " hitB"},  cntHitBwd,  refHitB);
    chk({req, " missF"}, cntMissFwd, refMissF);
    chk({req, " missB"}, cntMissBwd, refMissB);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    refReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 hist", predHist, 0);
    chkCounters("R1");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      predPc = 32'h1000 + 32'(i * 6); predBackward = i[0];
      #1;
      chk("R1 R2 static", predTaken, i[0]);
    end
  endtask

  // loop branch: 7 taken then one exit, repeated
  task automatic tLoop();
    for (int r = 0; r < 5; r++)
      for (int k = 0; k < 8; k++)
        lookAndUpdate("R3 R4 loop", 32'h0000_0140, 1'b1, k != 7);
    chkCounters("R8 loop");
  endtask

  // alternating forward branch: gselect learns it, selector moves over
  task automatic tAlternate();
    for (int k = 0; k < 24; k++)
      lookAndUpdate("R4 R5 alt", 32'h0000_0206, 1'b0, k[0]);
    chk("R4 saturate", refCh[32'h206 >> 1 & 63], 7);
    for (int k = 0; k < 6; k++)
      lookAndUpdate("R5 alt gs", 32'h0000_0206, 1'b0, k[0]);
    chkCounters("R8 alt");
  endtask

  // update with an older carried history
  task automatic tCarried();
    bit [5:0] oldH;
    look("R7 pre", 32'h0000_0206, 1'b0);
    oldH = predHist;
    update(32'h0000_0300, 1'b0, refHist, 1'b1);
    update(32'h0000_0302, 1'b1, refHist, 1'b1);
    update(32'h0000_0206, 1'b0, oldH, ~refGs[{oldH, 2'b11}]);
    // walk the history back to oldH through another branch
    for (int b = 5; b >= 0; b--)
      update(32'h0000_0400, 1'b0, refHist, oldH[b]);
    chk("R7 hist back", predHist, oldH);
    look("R7 carried", 32'h0000_0206, 1'b0);
    for (int p = 0; p < 4; p++) look("R7 sweep", 32'h0000_0200 + 32'(p * 2), 1'b0);
  endtask

  // lookup and update together on the same entry
  task automatic tSame();
    bit expPre;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      predPc = 32'h0000_0206; predBackward = 1'b0;
      updValid = 1'b1; updPc = 32'h0000_0206; updBackward = 1'b0;
      updHist = refHist; updTaken = ~refGs[{refHist, 2'b11}];
      expPre = refGuess(32'h206, 1'b0, refHist);
      #1;
      chk("R9 same cycle", predTaken, expPre);
      refUpdate(32'h206, 1'b0, updHist, updTaken);
      @(negedge clk);
      updValid = 1'b0;
      #1;
      chk("R9 after", predTaken, refGuess(32'h206, 1'b0, refHist));
    end
    chkCounters("R8 same");
  endtask

  // idle cycles with noise on update inputs
  task automatic tIdle();
    bit [5:0] h0;
    h0 = predHist;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      updValid = 1'b0; updPc = 32'h0000_0206 + 32'(k * 2);
      updBackward = k[1]; updHist = 6'(k * 11); updTaken = k[0];
    end
    @(negedge clk); #1;
    chk("R10 hist", predHist, h0);
    chkCounters("R10");
    look("R10 table", 32'h0000_0206, 1'b0);
    look("R10 table b", 32'h0000_0140, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tLoop();
    tAlternate();
    tCarried();
    tSame();
    tIdle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule